// File: doc/BRIEF.md
# Debug Mailbox Between Processor and Host Debugger

This block is a two-way message box that lets software running on a processor exchange 32-bit words with an external debugger. Each direction has its own data word and its own handshake flag. The debugger deposits a word for the processor in the inbound word. The processor deposits a word for the debugger in the outbound word. Each flag is raised by the side that writes its word and dropped by the side that reads that word. The two flags are also driven onto two level pins, so that interrupt or polling logic elsewhere can see that a message is waiting without doing a read.

Both sides use the same kind of simple register port. A port has a write strobe, a read strobe, a one-bit select and a data word in each direction. The select picks either the data word or a status word that carries both flags. On the processor side this port takes the place of coprocessor register transfers. On the debugger side it takes the place of the serial scan access. Read data comes back combinationally in the same cycle as the read strobe. The flag updates caused by a read or a write are seen from the next cycle.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset both flags are 0, both data words are 0, and rx_pending and tx_pending are low.
- R2: A host write with host_sel=0 loads host_wdata into the inbound word. From the next cycle the inbound flag is 1 and rx_pending is high.
- R3: A processor read with cpu_sel=0 returns the inbound word on cpu_rdata in that same cycle. From the next cycle it clears the inbound flag.
- R4: A processor write with cpu_sel=0 loads cpu_wdata into the outbound word. From the next cycle the outbound flag is 1 and tx_pending is high.
- R5: A host read with host_sel=0 returns the outbound word on host_rdata in that same cycle. From the next cycle it clears the outbound flag.
- R6: A read with sel=1 on either port returns the status word: bit 0 is the inbound flag, bit 1 is the outbound flag, and all other bits are 0. A status read changes no flag.
- R7: A write with sel=1 on either port is ignored. No flag and no data word changes.
- R8: A write to a data word whose flag is already set replaces the stored word, and the flag stays set.
- R9: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: While a port's read strobe is low, its read data is all zeros.
- R11: A flag keeps its value in any cycle with no set and no clear of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_rd_en | input | 1 | Processor read strobe |
| cpu_sel | input | 1 | Processor select: 0 data, 1 status |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data |
| host_wr_en | input | 1 | Debugger write strobe |
| host_rd_en | input | 1 | Debugger read strobe |
| host_sel | input | 1 | Debugger select: 0 data, 1 status |
| host_wdata | input | 32 | Debugger write data |
| host_rdata | output | 32 | Debugger read data |
| rx_pending | output | 1 | Inbound word is waiting for the processor |
| tx_pending | output | 1 | Outbound word is waiting for the debugger |

## Verification
Each flag can be set by one side and cleared by the other side in the same cycle. For example, a debugger write to the inbound word can coincide with the processor reading that word. The directed part of the bench lines up exactly such a collision on each channel and expects the flag to be set afterwards, with the new word stored and the old word returned by the read. The random part drives both ports with independent strobes every cycle, so these collisions also come up many times. It compares every read and pin against a reference model in which set has priority.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;
   // port select encoding
   typedef enum logic {
      SEL_DATA   = 1'b0,
      SEL_STATUS = 1'b1
   } mbx_sel_e;

   // status word bit positions
   localparam int unsigned STAT_RX_BIT = 0;
   localparam int unsigned STAT_TX_BIT = 1;
   localparam int unsigned STAT_BITS   = 2;

   // channel indices
   localparam int unsigned CH_IN   = 0;
   localparam int unsigned CH_OUT  = 1;
   localparam int unsigned NUM_CH  = 2;
endpackage

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end
endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (load_i)
         q_o <= d_i;
   end
endmodule

// File: rtl/mbx_readmux.sv
module mbx_readmux
   import dbg_mailbox_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              rd_en_i,
   input  logic              sel_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              rx_flag_i,
   input  logic              tx_flag_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] status_w;

   always_comb begin
      status_w = '0;
      status_w[STAT_RX_BIT] = rx_flag_i;
      status_w[STAT_TX_BIT] = tx_flag_i;
   end

   always_comb begin
      if (!rd_en_i)
         rdata_o = '0;
      else if (mbx_sel_e'(sel_i) == SEL_STATUS)
         rdata_o = status_w;
      else
         rdata_o = data_i;
   end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
   import dbg_mailbox_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic              cpu_rd_en,
   input  logic              cpu_sel,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              host_wr_en,
   input  logic              host_rd_en,
   input  logic              host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              rx_pending,
   output logic              tx_pending
);
   generate
      if (DATA_W < STAT_BITS) begin : g_bad_width
         $error("dbg_mailbox: DATA_W must hold the status bits");
      end
   endgenerate

   logic              cpu_data_wr, cpu_data_rd;
   logic              host_data_wr, host_data_rd;
   logic [NUM_CH-1:0] ch_load, ch_take, ch_flag;
   logic [DATA_W-1:0] ch_din  [NUM_CH];
   logic [DATA_W-1:0] ch_word [NUM_CH];

   assign cpu_data_wr  = cpu_wr_en  && (mbx_sel_e'(cpu_sel)  == SEL_DATA);
   assign cpu_data_rd  = cpu_rd_en  && (mbx_sel_e'(cpu_sel)  == SEL_DATA);
   assign host_data_wr = host_wr_en && (mbx_sel_e'(host_sel) == SEL_DATA);
   assign host_data_rd = host_rd_en && (mbx_sel_e'(host_sel) == SEL_DATA);

   // inbound: written by host, taken by processor
   assign ch_load[CH_IN]  = host_data_wr;
   assign ch_take[CH_IN]  = cpu_data_rd;
   assign ch_din[CH_IN]   = host_wdata;
   // outbound: written by processor, taken by host
   assign ch_load[CH_OUT] = cpu_data_wr;
   assign ch_take[CH_OUT] = host_data_rd;
   assign ch_din[CH_OUT]  = cpu_wdata;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         mbx_word #(.DATA_W(DATA_W)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (ch_load[c]),
            .d_i    (ch_din[c]),
            .q_o    (ch_word[c])
         );
         mbx_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ch_load[c]),
            .clr_i  (ch_take[c]),
            .flag_o (ch_flag[c])
         );
      end
   endgenerate

   mbx_readmux #(.DATA_W(DATA_W)) u_cpu_rd (
      .rd_en_i   (cpu_rd_en),
      .sel_i     (cpu_sel),
      .data_i    (ch_word[CH_IN]),
      .rx_flag_i (ch_flag[CH_IN]),
      .tx_flag_i (ch_flag[CH_OUT]),
      .rdata_o   (cpu_rdata)
   );

   mbx_readmux #(.DATA_W(DATA_W)) u_host_rd (
      .rd_en_i   (host_rd_en),
      .sel_i     (host_sel),
      .data_i    (ch_word[CH_OUT]),
      .rx_flag_i (ch_flag[CH_IN]),
      .tx_flag_i (ch_flag[CH_OUT]),
      .rdata_o   (host_rdata)
   );

   assign rx_pending = ch_flag[CH_IN];
   assign tx_pending = ch_flag[CH_OUT];
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr_en,
   input logic              cpu_rd_en,
   input logic              cpu_sel,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              host_wr_en,
   input logic              host_rd_en,
   input logic              host_sel,
   input logic [DATA_W-1:0] host_wdata,
   input logic [DATA_W-1:0] host_rdata,
   input logic              rx_pending,
   input logic              tx_pending
);
   logic [DATA_W-1:0] stat_w;
   always_comb begin
      stat_w = '0;
      stat_w[0] = rx_pending;
      stat_w[1] = tx_pending;
   end

   assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && !host_sel) |=> rx_pending);

   assert_tx_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_en && !cpu_sel) |=> tx_pending);

   assert_rx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_en && !cpu_sel && !(host_wr_en && !host_sel)) |=> !rx_pending);

   assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && !host_sel && !(cpu_wr_en && !cpu_sel)) |=> !tx_pending);

   assert_cpu_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_en && cpu_sel) |-> (cpu_rdata == stat_w));

   assert_host_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && host_sel) |-> (host_rdata == stat_w));

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rd_en |-> (cpu_rdata == '0)) and (!host_rd_en |-> (host_rdata == '0)));

   assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(host_wr_en && !host_sel) && !(cpu_rd_en && !cpu_sel)) |=> $stable(rx_pending));

   assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cpu_wr_en && !cpu_sel) && !(host_rd_en && !host_sel)) |=> $stable(tx_pending));

   assert_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(host_wr_en && !host_sel) && cpu_rd_en && !cpu_sel)
      |-> (cpu_rdata == $past(host_wdata)));

   assert_out_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cpu_wr_en && !cpu_sel) && host_rd_en && !host_sel)
      |-> (host_rdata == $past(cpu_wdata)));
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_wr_en  (cpu_wr_en),
   .cpu_rd_en  (cpu_rd_en),
   .cpu_sel    (cpu_sel),
   .cpu_wdata  (cpu_wdata),
   .cpu_rdata  (cpu_rdata),
   .host_wr_en (host_wr_en),
   .host_rd_en (host_rd_en),
   .host_sel   (host_sel),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .rx_pending (rx_pending),
   .tx_pending (tx_pending)
);

// File: tb/sim_dbg_mailbox.sv
module sim_dbg_mailbox;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_wr_en = 0, cpu_rd_en = 0, cpu_sel = 0;
   logic [W-1:0] cpu_wdata = '0, cpu_rdata;
   logic         host_wr_en = 0, host_rd_en = 0, host_sel = 0;
   logic [W-1:0] host_wdata = '0, host_rdata;
   logic         rx_pending, tx_pending;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model
   logic [W-1:0] m_in = '0, m_out = '0;
   logic         m_rx = 0, m_tx = 0;

   always #4 clk = ~clk;

   dbg_mailbox #(.DATA_W(W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en), .cpu_sel(cpu_sel),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .rx_pending(rx_pending), .tx_pending(tx_pending)
   );

   function automatic logic [W-1:0] exp_read(input logic rd, input logic sel,
                                             input logic [W-1:0] word);
      logic [W-1:0] s;
      s = '0;
      s[0] = m_rx;
      s[1] = m_tx;
      if (!rd)      return '0;
      else if (sel) return s;
      else          return word;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drives one cycle at the negedge, checks before the next posedge, then updates the model
   task automatic step(input logic cwr, input logic crd, input logic csel, input logic [W-1:0] cwd,
                       input logic hwr, input logic hrd, input logic hsel, input logic [W-1:0] hwd);
      string tc, th;
      cpu_wr_en = cwr; cpu_rd_en = crd; cpu_sel = csel; cpu_wdata = cwd;
      host_wr_en = hwr; host_rd_en = hrd; host_sel = hsel; host_wdata = hwd;
      #1;
      tc = !crd ? "R10" : (csel ? "R6" : "R3");
      th = !hrd ? "R10" : (hsel ? "R6" : "R5");
      check(tc, cpu_rdata, exp_read(crd, csel, m_in));
      check(th, host_rdata, exp_read(hrd, hsel, m_out));
      check("R2", {{(W-1){1'b0}}, rx_pending}, {{(W-1){1'b0}}, m_rx});
      check("R4", {{(W-1){1'b0}}, tx_pending}, {{(W-1){1'b0}}, m_tx});
      @(posedge clk);
      if (hwr && !hsel) begin m_in = hwd; m_rx = 1; end
      else if (crd && !csel) m_rx = 0;
      if (cwr && !csel) begin m_out = cwd; m_tx = 1; end
      else if (hrd && !hsel) m_tx = 0;
      @(negedge clk);
   endtask

   task automatic idle();
      step(0, 0, 0, '0, 0, 0, 0, '0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state seen at the pins and through status reads
      check("R1", {{(W-2){1'b0}}, tx_pending, rx_pending}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      step(0, 1, 1, '0, 0, 1, 1, '0);   // status reads, R1
      step(0, 1, 0, '0, 0, 1, 0, '0);   // data words still zero, R1

      // R2 / R3 directed
      step(0, 0, 0, '0, 1, 0, 0, 32'hCAFE_0001);
      check("R2", {31'b0, rx_pending}, 32'd1);
      step(0, 1, 0, '0, 0, 0, 0, '0);
      // R4 / R5 directed
      step(1, 0, 0, 32'h1234_5678, 0, 0, 0, '0);
      check("R4", {31'b0, tx_pending}, 32'd1);
      step(0, 0, 0, '0, 0, 1, 0, '0);
      check("R5", {31'b0, tx_pending}, 32'd0);

      // R8: overwrite while full
      step(0, 0, 0, '0, 1, 0, 0, 32'h0000_00AA);
      step(0, 0, 0, '0, 1, 0, 0, 32'h0000_00BB);
      check("R8", {31'b0, rx_pending}, 32'd1);
      step(0, 1, 0, '0, 0, 0, 0, '0);   // expects 0xBB

      // R7: status writes ignored, visible through pins and data reads
      step(1, 0, 1, 32'hFFFF_FFFF, 1, 0, 1, 32'hFFFF_FFFF);
      check("R7", {30'b0, tx_pending, rx_pending}, 32'd0);
      step(0, 1, 0, '0, 0, 1, 0, '0);   // words unchanged, R7

      // R9: set and clear on the same flag in one cycle
      step(0, 0, 0, '0, 1, 0, 0, 32'h0000_0111);
      step(0, 1, 0, '0, 1, 0, 0, 32'h0000_0222);
      check("R9", {31'b0, rx_pending}, 32'd1);
      step(1, 0, 0, 32'h0000_0333, 0, 0, 0, '0);
      step(1, 0, 0, 32'h0000_0444, 0, 1, 0, '0);
      check("R9", {31'b0, tx_pending}, 32'd1);

      // R11: flags hold through idle cycles, R6 status read has no side effect
      idle(); idle();
      step(0, 1, 1, '0, 0, 1, 1, '0);
      check("R11", {30'b0, tx_pending, rx_pending}, 32'd3);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         step($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
              $urandom(),
              $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
              $urandom());
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule